// File: doc/BRIEF.md
# Serial Memory Controller Interrupt Status and Mask Unit

This block collects status for a serial memory controller and turns it into one interrupt line. Level conditions from the datapath, such as receive data full, transmit ready, transmitter idle, chip-select level and controller enabled, pass straight through into a status word. Single-cycle event pulses for overrun, chip-select rise and instruction end are caught in sticky flags. A status read clears those flags.

The interrupt mask cannot be written directly. Software sets mask bits by writing ones to an enable register and clears them by writing ones to a disable register. The mask itself can be read back at its own offset. The interrupt output is a level that stays high while any status bit is set under a set mask bit. A separate command-done output goes high only once both the instruction-end flag and the chip-select-rise flag are latched.

The register bus is a plain single-cycle interface with address, write enable, write data, read enable and read data. Read data is combinational while read enable is high. A read of the status word clears the event flags at the clock edge that ends the read cycle.

Top module: `sm_irq_ctrl`

## Requirements
- R1: After reset the event flags and the whole mask are zero, so with all level inputs low the status and mask both read 0 and irq is low.
- R2: The status word (offset 0x10) places receive-full at bit 0, transmit-ready at bit 1, transmitter-idle at bit 2, overrun at bit 3, chip-select-rise at bit 8, chip-select level at bit 9, instruction-end at bit 10 and controller-enabled at bit 24. All other bits read 0, and the level bits follow their inputs live.
- R3: An event pulse sets its status flag at the next clock edge. The flag stays set, whatever other traffic occurs, until the status word is read.
- R4: A status read clears the overrun, chip-select-rise and instruction-end flags at the end of the read cycle. The level bits are not affected.
- R5: An event pulse in the same cycle as a status read leaves its flag set after that read.
- R6: Writing to the enable register (offset 0x14) sets each mask bit whose data bit is 1 and that is one of the eight status positions of R2. Zero bits and other positions leave the mask unchanged.
- R7: Writing to the disable register (offset 0x18) clears each mask bit whose data bit is 1. Zero bits leave the mask unchanged.
- R8: The mask reads back at offset 0x1C. Writes to offset 0x1C or to the status offset 0x10 change neither the mask nor the event flags.
- R9: irq is high exactly when the bitwise AND of the status word and the mask is non-zero.
- R10: cmd_done is high exactly when both the instruction-end flag and the chip-select-rise flag are latched.
- R11: bus_rdata is 0 when bus_re is low, and also when reading the enable register, the disable register or any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| lvl_rx_full | input | 1 | Receive data available (live) |
| lvl_tx_ready | input | 1 | Transmit holding register free (live) |
| lvl_tx_idle | input | 1 | Shifter and holding register empty (live) |
| lvl_cs_state | input | 1 | Chip-select deasserted level (live) |
| lvl_enabled | input | 1 | Controller enabled (live) |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_cs_rise | input | 1 | Chip-select rise event pulse |
| ev_instr_end | input | 1 | Instruction end event pulse |
| irq | output | 1 | Level interrupt |
| cmd_done | output | 1 | Instruction end and chip-select rise both latched |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as a status read, because the set and the clear of the flag then act at the same edge. The bench drives this directly, and a random phase produces it again many times while other event pulses and mask writes are in flight. A second narrow case is cmd_done, which needs two flags that normally arrive at different times. The stimulus raises them in separate cycles, with a status read between two tries, to check that a partial completion is dropped by the read.

// File: rtl/sm_irq_pkg.sv
package sm_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_EV  = 3;

  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_IEN    = 8'h14;
  localparam logic [7:0] OFF_IDIS   = 8'h18;
  localparam logic [7:0] OFF_MASK   = 8'h1C;

  localparam int unsigned B_RXFULL  = 0;
  localparam int unsigned B_TXRDY   = 1;
  localparam int unsigned B_TXIDLE  = 2;
  localparam int unsigned B_OVR     = 3;
  localparam int unsigned B_CSRISE  = 8;
  localparam int unsigned B_CSLVL   = 9;
  localparam int unsigned B_INSTEND = 10;
  localparam int unsigned B_ENA     = 24;

  // index of each sticky event inside the flag vector
  localparam int unsigned EV_OVR     = 0;
  localparam int unsigned EV_CSRISE  = 1;
  localparam int unsigned EV_INSTEND = 2;

  localparam logic [REG_W-1:0] IMPL_BITS =
      (REG_W'(1) << B_RXFULL) | (REG_W'(1) << B_TXRDY)  | (REG_W'(1) << B_TXIDLE) |
      (REG_W'(1) << B_OVR)    | (REG_W'(1) << B_CSRISE) | (REG_W'(1) << B_CSLVL)  |
      (REG_W'(1) << B_INSTEND)| (REG_W'(1) << B_ENA);

  typedef struct packed {
    logic rx_full;
    logic tx_ready;
    logic tx_idle;
    logic cs_state;
    logic enabled;
  } lvl_t;

  function automatic logic [REG_W-1:0] pack_status(lvl_t lv, logic [NUM_EV-1:0] ev);
    logic [REG_W-1:0] s;
    s = '0;
    s[B_RXFULL]  = lv.rx_full;
    s[B_TXRDY]   = lv.tx_ready;
    s[B_TXIDLE]  = lv.tx_idle;
    s[B_CSLVL]   = lv.cs_state;
    s[B_ENA]     = lv.enabled;
    s[B_OVR]     = ev[EV_OVR];
    s[B_CSRISE]  = ev[EV_CSRISE];
    s[B_INSTEND] = ev[EV_INSTEND];
    return s;
  endfunction
endpackage

// File: rtl/sm_irq_evt_latch.sv
module sm_irq_evt_latch #(
  parameter int unsigned NUM_EV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_pulse,
  input  logic              clr_req,
  output logic [NUM_EV-1:0] ev_flag
);
  logic [NUM_EV-1:0] flag_q;
  logic [NUM_EV-1:0] flag_d;
  logic              upd_en;

  // new pulse wins over a read clear so no event is lost
  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    always_comb flag_d[i] = ev_pulse[i] | (flag_q[i] & ~clr_req);
  end

  always_comb upd_en = clr_req | (|ev_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  assign ev_flag = flag_q;
endmodule

// File: rtl/sm_irq_mask_reg.sv
module sm_irq_mask_reg #(
  parameter int unsigned          W    = 32,
  parameter logic [W-1:0]         IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         upd_en;

  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_q | (wdata & IMPL);
    if (clr_en) mask_d = mask_d & ~wdata;
    upd_en = set_en | clr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (upd_en) mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/sm_irq_rdmux.sv
module sm_irq_rdmux #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned W      = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              re,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      mask,
  output logic [W-1:0]      rdata
);
  import sm_irq_pkg::*;

  always_comb begin
    rdata = '0;
    if (re) begin
      if (addr == ADDR_W'(OFF_STATUS))    rdata = status;
      else if (addr == ADDR_W'(OFF_MASK)) rdata = mask;
    end
  end
endmodule

// File: rtl/sm_irq_ctrl.sv
module sm_irq_ctrl #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              lvl_rx_full,
  input  logic              lvl_tx_ready,
  input  logic              lvl_tx_idle,
  input  logic              lvl_cs_state,
  input  logic              lvl_enabled,
  input  logic              ev_overrun,
  input  logic              ev_cs_rise,
  input  logic              ev_instr_end,
  output logic              irq,
  output logic              cmd_done
);
  import sm_irq_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  logic              st_rd;
  logic              ien_wr;
  logic              idis_wr;
  logic [NUM_EV-1:0] ev_vec;
  logic [NUM_EV-1:0] ev_flag;
  logic [REG_W-1:0]  mask_val;
  logic [REG_W-1:0]  status_val;
  lvl_t              lvl;

  always_comb begin
    st_rd   = bus_re && (bus_addr == ADDR_W'(OFF_STATUS));
    ien_wr  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
    idis_wr = bus_we && (bus_addr == ADDR_W'(OFF_IDIS));
    ev_vec  = '0;
    ev_vec[EV_OVR]     = ev_overrun;
    ev_vec[EV_CSRISE]  = ev_cs_rise;
    ev_vec[EV_INSTEND] = ev_instr_end;
    lvl = '{rx_full: lvl_rx_full, tx_ready: lvl_tx_ready, tx_idle: lvl_tx_idle,
            cs_state: lvl_cs_state, enabled: lvl_enabled};
  end

  sm_irq_evt_latch #(.NUM_EV(NUM_EV)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ev_pulse (ev_vec),
    .clr_req  (st_rd),
    .ev_flag  (ev_flag)
  );

  sm_irq_mask_reg #(.W(REG_W), .IMPL(IMPL_BITS)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_en (ien_wr),
    .clr_en (idis_wr),
    .wdata  (bus_wdata),
    .mask   (mask_val)
  );

  always_comb status_val = pack_status(lvl, ev_flag);

  sm_irq_rdmux #(.ADDR_W(ADDR_W), .W(REG_W)) u_rd (
    .addr   (bus_addr),
    .re     (bus_re),
    .status (status_val),
    .mask   (mask_val),
    .rdata  (bus_rdata)
  );

  always_comb begin
    irq      = |(status_val & mask_val);
    cmd_done = ev_flag[EV_INSTEND] & ev_flag[EV_CSRISE];
  end
endmodule

// File: rtl/sm_irq_ctrl_chk.sv
module sm_irq_ctrl_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              ev_overrun,
  input logic              ev_cs_rise,
  input logic              ev_instr_end,
  input logic              cmd_done,
  input logic              irq,
  input logic [2:0]        ev_flag,
  input logic [31:0]       mask_q
);
  import sm_irq_pkg::*;

  logic [2:0] ev_vec;
  logic       st_rd;
  logic       en_wr;
  logic       dis_wr;

  assign ev_vec = {ev_instr_end, ev_cs_rise, ev_overrun};
  assign st_rd  = bus_re && (bus_addr == ADDR_W'(OFF_STATUS));
  assign en_wr  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
  assign dis_wr = bus_we && (bus_addr == ADDR_W'(OFF_IDIS));

  p_ev_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((ev_flag & $past(ev_vec)) == $past(ev_vec)));

  p_ev_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_rd && ev_vec == 3'b000) |=> $stable(ev_flag));

  p_rd_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && ev_vec == 3'b000) |=> (ev_flag == 3'b000));

  p_rd_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && |ev_vec) |=> (ev_flag == $past(ev_vec)));

  p_en_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((mask_q & $past(bus_wdata & IMPL_BITS)) == $past(bus_wdata & IMPL_BITS)));

  p_dis_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> ((mask_q & $past(bus_wdata)) == 32'h0));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_wr || dis_wr) |=> $stable(mask_q));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'h0) |-> !irq);

  p_done_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> $past(ev_cs_rise || ev_instr_end));

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == 32'h0));
endmodule

bind sm_irq_ctrl sm_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_re       (bus_re),
  .bus_rdata    (bus_rdata),
  .ev_overrun   (ev_overrun),
  .ev_cs_rise   (ev_cs_rise),
  .ev_instr_end (ev_instr_end),
  .cmd_done     (cmd_done),
  .irq          (irq),
  .ev_flag      (ev_flag),
  .mask_q       (mask_val)
);

// File: tb/sm_irq_ctrl_bench.sv
module sm_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_addr = '0;
  logic        a_we = 1'b0;
  logic [31:0] a_wdata = '0;
  logic        a_re = 1'b0;
  logic [4:0]  lv = '0;   // {enabled, cs_state, tx_idle, tx_ready, rx_full}
  logic [2:0]  ev = '0;   // {instr_end, cs_rise, overrun}
  logic [31:0] rdata;
  logic        irq;
  logic        cmd_done;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit [2:0]  m_flag = '0;
  bit [31:0] m_mask = '0;
  localparam bit [31:0] VALID = 32'h0100_070F;

  always #4 clk = ~clk;

  sm_irq_ctrl u_sm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_we(a_we), .bus_wdata(a_wdata),
    .bus_re(a_re), .bus_rdata(rdata),
    .lvl_rx_full(lv[0]), .lvl_tx_ready(lv[1]), .lvl_tx_idle(lv[2]),
    .lvl_cs_state(lv[3]), .lvl_enabled(lv[4]),
    .ev_overrun(ev[0]), .ev_cs_rise(ev[1]), .ev_instr_end(ev[2]),
    .irq(irq), .cmd_done(cmd_done)
  );

  function automatic bit [31:0] m_status();
    return (32'(lv[0]) << 0) | (32'(lv[1]) << 1) | (32'(lv[2]) << 2) |
           (32'(m_flag[0]) << 3) | (32'(m_flag[1]) << 8) | (32'(lv[3]) << 9) |
           (32'(m_flag[2]) << 10) | (32'(lv[4]) << 24);
  endfunction

  task automatic chk(string tag, string what, bit [31:0] got, bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // compare outputs mid-cycle, then advance the model across the edge
  task automatic cyc(string tag);
    bit [31:0] exp_rd;
    #1;
    exp_rd = 32'h0;
    if (a_re && a_addr == 8'h10) exp_rd = m_status();
    else if (a_re && a_addr == 8'h1C) exp_rd = m_mask;
    chk(tag, "rdata", rdata, exp_rd);
    chk(tag, "irq", 32'(irq), 32'(|(m_status() & m_mask)));
    chk(tag, "cmd_done", 32'(cmd_done), 32'(m_flag[1] & m_flag[2]));
    @(posedge clk);
    if (a_re && a_addr == 8'h10) m_flag = ev;
    else m_flag = m_flag | ev;
    if (a_we && a_addr == 8'h14) m_mask = m_mask | (a_wdata & VALID);
    if (a_we && a_addr == 8'h18) m_mask = m_mask & ~a_wdata;
    @(negedge clk);
    a_we = 0; a_re = 0; ev = '0; a_addr = '0; a_wdata = '0;
  endtask

  task automatic rd(bit [7:0] ad, string tag);
    a_addr = ad; a_re = 1; cyc(tag);
  endtask

  task automatic wr(bit [7:0] ad, bit [31:0] d, string tag);
    a_addr = ad; a_we = 1; a_wdata = d; cyc(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    rd(8'h1C, "R1"); rd(8'h10, "R1"); cyc("R1");
    // R2: level layout, live
    lv = 5'b11111; rd(8'h10, "R2");
    lv = 5'b10101; rd(8'h10, "R2");
    // R11: non-readable offsets
    rd(8'h14, "R11"); rd(8'h18, "R11"); rd(8'h04, "R11"); cyc("R11");
    // R3: overrun latched and held
    ev = 3'b001; cyc("R3");
    cyc("R3"); wr(8'h1C, 32'hFFFF_FFFF, "R3"); rd(8'h1C, "R3");
    rd(8'h10, "R3");
    // R4: read cleared flags, levels remain
    rd(8'h10, "R4");
    // R5: event with read
    ev = 3'b100; cyc("R5");
    ev = 3'b010; rd(8'h10, "R5");
    rd(8'h10, "R5"); rd(8'h10, "R5");
    // R6: enable set
    wr(8'h14, 32'hFFFF_FFFF, "R6"); rd(8'h1C, "R6");
    wr(8'h14, 32'h0, "R6"); rd(8'h1C, "R6");
    // R7: disable clear
    wr(8'h18, 32'h0000_0105, "R7"); rd(8'h1C, "R7");
    wr(8'h18, 32'h0, "R7"); rd(8'h1C, "R7");
    wr(8'h18, 32'hFFFF_FFFF, "R7"); rd(8'h1C, "R7");
    // R8: writes to mask and status offsets ignored
    ev = 3'b001; cyc("R8");
    wr(8'h1C, 32'hFFFF_FFFF, "R8"); wr(8'h10, 32'hFFFF_FFFF, "R8");
    rd(8'h1C, "R8"); rd(8'h10, "R8");
    // R9: irq from one unmasked bit
    lv = '0; wr(8'h14, 32'h8, "R9");
    ev = 3'b001; cyc("R9"); cyc("R9");
    rd(8'h10, "R9"); cyc("R9");
    lv = 5'b10000; wr(8'h14, 32'h0100_0000, "R9");
    wr(8'h18, 32'h0100_0000, "R9"); cyc("R9");
    // R10: two-flag completion
    ev = 3'b100; cyc("R10"); cyc("R10");
    rd(8'h10, "R10");
    ev = 3'b010; cyc("R10"); cyc("R10");
    ev = 3'b100; cyc("R10"); cyc("R10");
    rd(8'h10, "R10"); cyc("R10");
    ev = 3'b110; cyc("R10"); cyc("R10");
    rd(8'h10, "R10");
    // random traffic for all of R3..R9
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 5);
      lv = 5'($urandom);
      ev = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      case (sel)
        0: wr(8'h14, $urandom, "R6");
        1: wr(8'h18, $urandom, "R7");
        2: rd(8'h10, "R4");
        3: rd(8'h1C, "R8");
        4: wr(8'h1C, $urandom, "R8");
        default: cyc("R9");
      endcase
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule